// File: doc/BRIEF.md
# Two's-Complement ALU with Condition Flags

This block is the integer execution unit of a small processor core. It takes two operands of a configurable width and an operation code, and it produces a result in the same cycle. It also computes four condition flags: negative (N), zero (Z), signed overflow (V) and carry (C). The flags are held in a register that loads only when the caller asks for it. Carry-dependent operations read their carry input from that register, so multi-word arithmetic and rotations through carry can be chained across cycles.

A branch-condition evaluator is attached to the flag register. It decodes a condition select into a branch-taken bit, which lets the sequencer resolve conditional branches directly from the stored flags.

Top module: `cc_alu`

## Requirements
- R1: Opcode 0 (add) gives result = A + B, and opcode 1 (add with carry) gives A + B + C, where C is the stored carry flag. In both cases the next C is the carry out of the top bit.
- R2: For add, add with carry, subtract, subtract with borrow, compare and negate, the next V is set exactly when the signed value of the true result does not fit in W bits. This is equivalent to the carry into the top bit differing from the carry out of it. For example, 8-bit 0x05 + 0x03 gives 0x08 with V=0, and 0x7F + 0x01 gives 0x80 with V=1.
- R3: Opcode 2 (subtract) computes A + ~B + 1. Opcode 3 (subtract with borrow) computes A + ~B + C. In both, the next C is the carry out, so C=1 means that no borrow occurred. For example, 8-bit 0xF0 - 0x14 gives 0xDC with N=1, Z=0, V=0 and C=1.
- R4: Opcode 4 (compare) sets the flags from A - B, exactly as subtract does. Opcode 5 (test) sets the flags from A AND B. For both opcodes the result port carries A unchanged.
- R5: For every other defined opcode, the next N equals the top bit of the result, and the next Z is 1 exactly when all result bits are 0.
- R6: Opcodes 6 (AND), 7 (OR), 8 (XOR), 9 (complement of A) and 5 (test) clear the next V and pass the stored C through unchanged.
- R7: Opcode 10 (negate) gives 0 - A. The next C is 1 only when A is 0, and the next V is 1 only when A is the most negative value.
- R8: Opcode 11 shifts A left by one and fills bit 0 with 0. Opcode 12 shifts A right by one and fills the top bit with 0. Opcode 13 shifts A right by one and keeps the sign bit. In all three, the bit shifted out becomes the next C and the next V is 0.
- R9: Opcode 14 rotates A left and opcode 15 rotates A right; in both, the bit rotated out also becomes the next C. Opcodes 16 (left) and 17 (right) rotate through carry: the stored C enters the vacated position and the bit shifted out becomes the next C. All four clear the next V.
- R10: The flag vector is packed {N,Z,V,C} in bits [3:0], and reset clears it to 0. On a clock edge it loads nextFlags only when flagWe is high and the opcode is defined (0 to 17). Otherwise it holds its value.
- R11: Opcodes 18 to 31 are undefined. They drive the result to 0, make nextFlags equal to the stored flags, and never change the flag register, even when flagWe is high.
- R12: branchTaken is decoded from the stored flags and condSel. The codes are: 0 when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=0, 5 when N=1, 6 when V=1, 7 when V=0. Any condSel with bit 3 set means always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the flag register |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| opCode | input | 5 | Operation select |
| flagWe | input | 1 | Allows the flag register to load this cycle |
| condSel | input | 4 | Branch condition select |
| result | output | W | Operation result |
| nextFlags | output | 4 | Flags this operation would produce, packed {N,Z,V,C} |
| flags | output | 4 | Stored flags, packed {N,Z,V,C} |
| branchTaken | output | 1 | Selected condition holds on the stored flags |

## Verification
The hardest cases to reach are the ones where the stored carry matters. These are add with carry, subtract with borrow, the rotates through carry, and logic operations that must carry C forward. Each needs an earlier operation to have left a particular C in the register, with flagWe high on that earlier cycle. The stimulus sets this up in two ways. Directed sequences first produce a chosen carry state and then apply the dependent operation. Long random streams mix all opcodes, interleave flagWe on and off, and switch condSel every cycle. Signed overflow at the most negative value, and the undefined opcodes arriving with flagWe high, are placed deliberately in the directed sweep.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_TST = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_NOT = 5'd9,  OP_NEG = 5'd10, OP_SHL = 5'd11,
    OP_SHR = 5'd12, OP_SAR = 5'd13, OP_ROL = 5'd14, OP_ROR = 5'd15,
    OP_RCL = 5'd16, OP_RCR = 5'd17
  } aluOp_e;

  typedef enum logic [1:0] {KIND_ARITH, KIND_LOGIC, KIND_SHIFT, KIND_NONE} kind_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOT} logic_e;
  typedef enum logic [2:0] {SH_SHL, SH_SHR, SH_SAR, SH_ROL, SH_ROR, SH_RCL, SH_RCR} shift_e;

  typedef struct packed {
    kind_e  kind;
    logic   negA;
    logic   invB;
    cin_e   cinSel;
    logic_e logicOp;
    shift_e shiftOp;
    logic   passA;
    logic   flagWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/cc_alu_ctrl.sv
module cc_alu_ctrl
  import cc_alu_pkg::*;
(
  input  logic [4:0]   opCode,
  output ctrlStrobes_t strb
);

  always_comb begin
    strb = '{kind: KIND_NONE, negA: 1'b0, invB: 1'b0, cinSel: CIN_ZERO,
             logicOp: LG_AND, shiftOp: SH_SHL, passA: 1'b0, flagWr: 1'b1};
    case (opCode)
      OP_ADD: strb.kind = KIND_ARITH;
      OP_ADC: begin strb.kind = KIND_ARITH; strb.cinSel = CIN_FLAG; end
      OP_SUB: begin strb.kind = KIND_ARITH; strb.invB = 1'b1; strb.cinSel = CIN_ONE; end
      OP_SBB: begin strb.kind = KIND_ARITH; strb.invB = 1'b1; strb.cinSel = CIN_FLAG; end
      OP_CMP: begin
        strb.kind = KIND_ARITH; strb.invB = 1'b1; strb.cinSel = CIN_ONE; strb.passA = 1'b1;
      end
      OP_TST: begin strb.kind = KIND_LOGIC; strb.logicOp = LG_AND; strb.passA = 1'b1; end
      OP_AND: begin strb.kind = KIND_LOGIC; strb.logicOp = LG_AND; end
      OP_OR:  begin strb.kind = KIND_LOGIC; strb.logicOp = LG_OR;  end
      OP_XOR: begin strb.kind = KIND_LOGIC; strb.logicOp = LG_XOR; end
      OP_NOT: begin strb.kind = KIND_LOGIC; strb.logicOp = LG_NOT; end
      OP_NEG: begin
        strb.kind = KIND_ARITH; strb.negA = 1'b1; strb.invB = 1'b1; strb.cinSel = CIN_ONE;
      end
      OP_SHL: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_SHL; end
      OP_SHR: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_SHR; end
      OP_SAR: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_SAR; end
      OP_ROL: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_ROL; end
      OP_ROR: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_ROR; end
      OP_RCL: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_RCL; end
      OP_RCR: begin strb.kind = KIND_SHIFT; strb.shiftOp = SH_RCR; end
      default: strb.flagWr = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_alu_datapath.sv
module cc_alu_datapath
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         flagWe,
  input  ctrlStrobes_t strb,
  output logic [W-1:0] result,
  output logic [3:0]   nextFlags,
  output logic [3:0]   flags
);

  localparam int LOW_W = W - 1;

  logic [W-1:0] addX, addY, addYRaw, lowSum, arithRes, logicRes, shiftRes, coreVal;
  logic [1:0]   topSum;
  logic         carryIn, cinBit, arithC, arithV, shiftC, storedC;

  assign storedC = flags[FLAG_C];

  // Adder split at the sign bit so the carry into it is visible.
  always_comb begin
    addX    = strb.negA ? '0 : opA;
    addYRaw = strb.negA ? opA : opB;
    addY    = strb.invB ? ~addYRaw : addYRaw;
    case (strb.cinSel)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = storedC;
      default:  cinBit = 1'b0;
    endcase
    lowSum   = {1'b0, addX[LOW_W-1:0]} + {1'b0, addY[LOW_W-1:0]} + {{LOW_W{1'b0}}, cinBit};
    carryIn  = lowSum[W-1];
    topSum   = {1'b0, addX[W-1]} + {1'b0, addY[W-1]} + {1'b0, carryIn};
    arithRes = {topSum[0], lowSum[LOW_W-1:0]};
    arithC   = topSum[1];
    arithV   = carryIn ^ topSum[1];
  end

  always_comb begin
    case (strb.logicOp)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOT:  logicRes = ~opA;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    case (strb.shiftOp)
      SH_SHR:  begin shiftRes = {1'b0, opA[W-1:1]};      shiftC = opA[0];   end
      SH_SAR:  begin shiftRes = {opA[W-1], opA[W-1:1]};  shiftC = opA[0];   end
      SH_ROL:  begin shiftRes = {opA[W-2:0], opA[W-1]};  shiftC = opA[W-1]; end
      SH_ROR:  begin shiftRes = {opA[0], opA[W-1:1]};    shiftC = opA[0];   end
      SH_RCL:  begin shiftRes = {opA[W-2:0], storedC};   shiftC = opA[W-1]; end
      SH_RCR:  begin shiftRes = {storedC, opA[W-1:1]};   shiftC = opA[0];   end
      default: begin shiftRes = {opA[W-2:0], 1'b0};      shiftC = opA[W-1]; end
    endcase
  end

  always_comb begin
    nextFlags = flags;
    case (strb.kind)
      KIND_ARITH: coreVal = arithRes;
      KIND_LOGIC: coreVal = logicRes;
      KIND_SHIFT: coreVal = shiftRes;
      default:    coreVal = '0;
    endcase
    if (strb.kind != KIND_NONE) begin
      nextFlags[FLAG_N] = coreVal[W-1];
      nextFlags[FLAG_Z] = (coreVal == '0);
      nextFlags[FLAG_V] = (strb.kind == KIND_ARITH) ? arithV : 1'b0;
      if (strb.kind == KIND_ARITH)      nextFlags[FLAG_C] = arithC;
      else if (strb.kind == KIND_SHIFT) nextFlags[FLAG_C] = shiftC;
    end
    result = strb.passA ? opA : coreVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flags <= 4'b0000;
    else if (flagWe && strb.flagWr)  flags <= nextFlags;
  end

endmodule

// File: rtl/cc_alu_branch.sv
module cc_alu_branch
  import cc_alu_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [3:0] condSel,
  output logic       branchTaken
);

  always_comb begin
    case (condSel[2:0])
      3'd0: branchTaken =  flags[FLAG_Z];
      3'd1: branchTaken = !flags[FLAG_Z];
      3'd2: branchTaken =  flags[FLAG_C];
      3'd3: branchTaken = !flags[FLAG_C];
      3'd4: branchTaken = !flags[FLAG_N];
      3'd5: branchTaken =  flags[FLAG_N];
      3'd6: branchTaken =  flags[FLAG_V];
      default: branchTaken = !flags[FLAG_V];
    endcase
    if (condSel[3]) branchTaken = 1'b1;
  end

endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [4:0]   opCode,
  input  logic         flagWe,
  input  logic [3:0]   condSel,
  output logic [W-1:0] result,
  output logic [3:0]   nextFlags,
  output logic [3:0]   flags,
  output logic         branchTaken
);

  ctrlStrobes_t strb;

  cc_alu_ctrl u_ctrl (.opCode(opCode), .strb(strb));

  cc_alu_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .flagWe(flagWe),
    .strb(strb), .result(result), .nextFlags(nextFlags), .flags(flags)
  );

  cc_alu_branch u_br (.flags(flags), .condSel(condSel), .branchTaken(branchTaken));

endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opA,
  input logic [4:0]   opCode,
  input logic         flagWe,
  input logic [3:0]   condSel,
  input logic [W-1:0] result,
  input logic [3:0]   nextFlags,
  input logic [3:0]   flags,
  input logic         branchTaken
);

  logic defOp, flagOnly, logicOp;
  assign defOp    = (opCode <= 5'd17);
  assign flagOnly = (opCode == 5'd4) || (opCode == 5'd5);
  assign logicOp  = (opCode >= 5'd5) && (opCode <= 5'd9);

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && defOp) |=> (flags == $past(nextFlags)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flagWe && defOp) |=> $stable(flags));

  p_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (defOp && !flagOnly) |-> (nextFlags[3] == result[W-1] && nextFlags[2] == (result == '0)));

  p_logic_keeps_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    logicOp |-> (!nextFlags[1] && nextFlags[0] == flags[0]));

  p_pass_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flagOnly |-> (result == opA));

  p_undefined_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !defOp |-> (result == '0 && nextFlags == flags));

  p_always_r12: assert property (@(posedge clk) disable iff (!rst_n)
    condSel[3] |-> branchTaken);

endmodule

bind cc_alu cc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opA(opA), .opCode(opCode), .flagWe(flagWe),
  .condSel(condSel), .result(result), .nextFlags(nextFlags), .flags(flags),
  .branchTaken(branchTaken)
);

// File: tb/cc_alu_bench.sv
`timescale 1ns/1ps
module cc_alu_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [4:0]   opCode = '0;
  logic         flagWe = 1'b0;
  logic [3:0]   condSel = '0;
  logic [W-1:0] result;
  logic [3:0]   nextFlags, flags;
  logic         branchTaken;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic [3:0] mFlags = 4'b0000;

  always #4 clk = ~clk;

  cc_alu #(.W(W)) u_cc_alu (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .opCode(opCode),
    .flagWe(flagWe), .condSel(condSel), .result(result),
    .nextFlags(nextFlags), .flags(flags), .branchTaken(branchTaken)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int op);
    case (op)
      0, 1:           return "R1";
      2, 3:           return "R3";
      4, 5:           return "R4";
      6, 7, 8, 9:     return "R6";
      10:             return "R7";
      11, 12, 13:     return "R8";
      14, 15, 16, 17: return "R9";
      default:        return "R11";
    endcase
  endfunction

  // Behavioural reference: integer arithmetic, signed range test for V.
  task automatic model(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] f, output logic [W-1:0] r, output logic [3:0] nf);
    int ua, ub, sa, sb, wide, sres, ci;
    logic [W-1:0] val;
    logic c, v;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    ci = int'(f[0]);
    c = f[0]; v = 1'b0; val = '0;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        wide = ua + ub + ci; val = wide[W-1:0]; c = (wide >= (1 << W));
        sres = sa + sb + ci;
        v = (sres > (1 << (W-1)) - 1) || (sres < -(1 << (W-1)));
      end
      2, 3, 4: begin
        int bo;
        bo = (op == 3) ? 1 - ci : 0;
        wide = ua - ub - bo; val = wide[W-1:0]; c = (wide >= 0);
        sres = sa - sb - bo;
        v = (sres > (1 << (W-1)) - 1) || (sres < -(1 << (W-1)));
      end
      5, 6: val = a & b;
      7:    val = a | b;
      8:    val = a ^ b;
      9:    val = ~a;
      10: begin
        wide = -ua; val = wide[W-1:0]; c = (ua == 0);
        v = (sa == -(1 << (W-1)));
      end
      11: begin val = a << 1; c = a[W-1]; end
      12: begin val = a >> 1; c = a[0]; end
      13: begin val = W'($signed(a) >>> 1); c = a[0]; end
      14: begin val = (a << 1) | (a >> (W-1)); c = a[W-1]; end
      15: begin val = (a >> 1) | (a << (W-1)); c = a[0]; end
      16: begin val = (a << 1) | W'(f[0]); c = a[W-1]; end
      17: begin val = (a >> 1) | (W'(f[0]) << (W-1)); c = a[0]; end
      default: ;
    endcase
    if (op > 17) begin
      r = '0; nf = f;
    end else begin
      r  = (op == 4 || op == 5) ? a : val;
      nf = {val[W-1], (val == '0), v, c};
    end
  endtask

  function automatic logic brModel(input logic [3:0] sel, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    if (sel >= 8) return 1'b1;
    case (sel)
      0: return z;
      1: return !z;
      2: return c;
      3: return !c;
      4: return !n;
      5: return n;
      6: return v;
      default: return !v;
    endcase
  endfunction

  task automatic step(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic we, input logic [3:0] cs);
    logic [W-1:0] er;
    logic [3:0] enf;
    @(negedge clk);
    opCode = 5'(op); opA = a; opB = b; flagWe = we; condSel = cs;
    #1;
    model(op, a, b, mFlags, er, enf);
    chk(result == er, tagOf(op), "result", 32'(result), 32'(er));
    chk(nextFlags == enf, (op == 0 || op == 1 || op == 2 || op == 3 || op == 10) ? "R2" : tagOf(op),
        "nextFlags", 32'(nextFlags), 32'(enf));
    if (op <= 17 && op != 4 && op != 5)
      chk(nextFlags[3:2] == {result[W-1], result == '0}, "R5", "N/Z", 32'(nextFlags[3:2]),
          32'({result[W-1], result == '0}));
    chk(branchTaken == brModel(cs, mFlags), "R12", "branchTaken", 32'(branchTaken),
        32'(brModel(cs, mFlags)));
    @(posedge clk);
    if (we && op <= 17) mFlags = enf;
    #1;
    chk(flags == mFlags, "R10", "flags", 32'(flags), 32'(mFlags));
  endtask

  initial begin
    logic [W-1:0] pats[6] = '{8'h00, 8'h80, 8'h7F, 8'hFF, 8'h01, 8'h5A};
    repeat (3) @(posedge clk);
    #1;
    chk(flags == 4'b0000, "R10", "reset flags", 32'(flags), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 worked example: 0xF0 - 0x14 = 0xDC, N=1 Z=0 V=0 C=1
    step(2, 8'hF0, 8'h14, 1'b1, 4'd2);
    chk(result == 8'hDC, "R3", "example result", 32'(result), 32'hDC);
    chk(flags == 4'b1001, "R3", "example flags", 32'(flags), 32'h9);
    // R2 examples
    step(0, 8'h05, 8'h03, 1'b1, 4'd6);
    chk(flags[1] == 1'b0, "R2", "5+3 V", 32'(flags[1]), 32'h0);
    step(0, 8'h7F, 8'h01, 1'b1, 4'd6);
    chk(flags[1] == 1'b1, "R2", "7F+1 V", 32'(flags[1]), 32'h1);
    // Carry chains: set C, then carry consumers (R1, R3, R9, R6)
    step(0, 8'hFF, 8'h01, 1'b1, 4'd2);
    step(1, 8'h10, 8'h20, 1'b1, 4'd3);
    step(11, 8'h80, 8'h00, 1'b1, 4'd2);
    step(3, 8'h10, 8'h10, 1'b1, 4'd3);
    step(11, 8'h80, 8'h00, 1'b1, 4'd2);
    step(16, 8'h01, 8'h00, 1'b1, 4'd2);
    step(17, 8'h02, 8'h00, 1'b1, 4'd2);
    step(6, 8'hF0, 8'h0F, 1'b1, 4'd0);
    step(10, 8'h80, 8'h00, 1'b1, 4'd6);
    step(10, 8'h00, 8'h00, 1'b1, 4'd2);
    // Undefined opcode with enable high must not touch flags (R11)
    step(25, 8'hFF, 8'hFF, 1'b1, 4'd1);
    // Sweep every opcode against boundary operands
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 6; i++)
        step(op, pats[i], pats[(i + 3) % 6], (i % 3) != 2, 4'((op + i) % 16));
    // Random stream
    for (int k = 0; k < 1500; k++)
      step(int'($urandom_range(0, 31)), W'($urandom), W'($urandom),
           1'($urandom_range(0, 3) != 0), 4'($urandom));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired before completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule